// File: doc/BRIEF.md
# Load-Switch Startup and Fault Sequencer

This block is the digital sequencer behind an electronic load switch. Comparators elsewhere turn the analog conditions into flags: overcurrent, output charged (the switch drop is below its threshold), thermal shutdown and thermal recovery. A 1 kHz tick-enable serves as the time base. The sequencer decides when the pass switch is closed, which current-limit multiplier the regulator applies, and whether the switch has been locked off.

On an enable request the switch closes after a short debounce. A startup window then runs in which the first part allows a raised current limit and the whole window ends in a check that the output has charged. Only after a successful startup is the two-bit fault-mode select read. The selected mode decides how an overcurrent and a thermal event are handled: locking off, off-then-retry, or limiting only. Removing the enable or pulsing `clear_fault` returns the sequencer to idle.

Top module: `lsw_seq_top`

## Requirements
- R1: The switch closes only after `enable` has been high through a 2-tick debounce. With `enable` low at a clock edge the switch is open after that edge, and any lock is released.
- R2: For the first 24 ticks with the switch closed after a startup begins, `ilim_mult` equals the boost code from `boost_cfg`. The codes are 00 = 1x, 01 = 1.5x, 10 = 2x, and 11 is taken as 2x. After those ticks `ilim_mult` is 00 (1x).
- R3: The startup window lasts 1200 ticks. If `out_charged` is low when the window ends, the switch opens and `latched_off` goes high.
- R4: Overcurrent is ignored during startup. `mode_sel` is read once, when the startup ends successfully, with 00 = lock off, 01 = retry, and 10 or 11 = continuous. Later changes to it have no effect.
- R5: In lock-off and retry modes, overcurrent held for 24 consecutive ticks opens the switch. Any cycle without overcurrent restarts that count.
- R6: In lock-off mode a trip holds the switch open with `latched_off` high until `enable` goes low or `clear_fault` is pulsed. `clear_fault` returns the sequencer to idle on the next edge.
- R7: In retry mode a trip holds the switch open with `retry_active` high for 720 ticks (30 times the blanking time). The startup then runs again, boost included.
- R8: In continuous mode overcurrent never opens the switch.
- R9: Thermal shutdown opens the switch at once. In lock-off mode it locks. In retry mode the sequencer waits for `therm_ok` and then runs the 720-tick retry. In continuous mode, and during startup, it waits for `therm_ok` and then runs only the 2-tick debounce.
- R10: All intervals advance only on cycles with `tick_ms` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | 1 kHz tick enable, one cycle wide |
| enable | input | 1 | Switch-on request, qualified |
| clear_fault | input | 1 | Synchronous return to idle |
| oc_det | input | 1 | Overcurrent comparator flag |
| out_charged | input | 1 | Switch drop below threshold |
| therm_sd | input | 1 | Thermal shutdown flag |
| therm_ok | input | 1 | Thermal recovery flag |
| mode_sel | input | 2 | Fault-mode select |
| boost_cfg | input | 2 | Startup multiplier configuration |
| sw_on | output | 1 | Switch enable |
| ilim_mult | output | 2 | Current-limit multiplier code |
| latched_off | output | 1 | Locked-off status |
| retry_active | output | 1 | Retry wait in progress |

## Verification
A wrong state or a mis-loaded mode shows at the ports as a switch that is open or closed against the selected mode within one clock of the triggering edge. A count that is off by one moves the edge of `sw_on`, `ilim_mult` or `retry_active` by one tick. For that reason every interval boundary is sampled on the last tick inside the interval and on the first tick after it. A mode sampled at the wrong time shows only at the next trip, so the bench changes the select after startup and then forces a trip.

// File: rtl/lsw_seq_pkg.sv
package lsw_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DEBOUNCE, S_START, S_RUN, S_RETRY, S_THERM, S_LATCH
  } seq_state_t;

  typedef enum logic [1:0] {
    M_LATCH = 2'b00,
    M_RETRY = 2'b01,
    M_CONT  = 2'b10
  } fault_mode_t;

  // select code to fault mode: upper bit set means continuous
  function automatic fault_mode_t decode_mode(input logic [1:0] sel);
    if (sel[1])      return M_CONT;
    else if (sel[0]) return M_RETRY;
    else             return M_LATCH;
  endfunction

  // configuration code to multiplier code: 11 folds onto 2x
  function automatic logic [1:0] boost_code(input logic [1:0] cfg);
    return (cfg == 2'b11) ? 2'b10 : cfg;
  endfunction

endpackage

// File: rtl/lsw_tick_timer.sv
module lsw_tick_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)               cnt <= '0;
    else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // last tick of a window of 'limit' ticks
  assign expire = tick && (cnt == limit - 1'b1);

endmodule

// File: rtl/lsw_mode_reg.sv
module lsw_mode_reg
  import lsw_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        force_cont,
  input  logic        sample,
  input  logic [1:0]  sel,
  output fault_mode_t mode
);
  always_ff @(posedge clk) begin
    if (!rst_n || force_cont) mode <= M_CONT;
    else if (sample)          mode <= decode_mode(sel);
  end
endmodule

// File: rtl/lsw_seq_top.sv
module lsw_seq_top
  import lsw_seq_pkg::*;
#(
  parameter int DEB_TICKS   = 2,
  parameter int STI_TICKS   = 24,
  parameter int STO_TICKS   = 1200,
  parameter int BLANK_TICKS = 24,
  parameter int RETRY_RATIO = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       enable,
  input  logic       clear_fault,
  input  logic       oc_det,
  input  logic       out_charged,
  input  logic       therm_sd,
  input  logic       therm_ok,
  input  logic [1:0] mode_sel,
  input  logic [1:0] boost_cfg,
  output logic       sw_on,
  output logic [1:0] ilim_mult,
  output logic       latched_off,
  output logic       retry_active
);
  localparam int RETRY_TICKS = BLANK_TICKS * RETRY_RATIO;
  localparam int LONGEST     = (STO_TICKS > RETRY_TICKS) ? STO_TICKS : RETRY_TICKS;
  localparam int CNT_W       = $clog2(LONGEST + 1);

  seq_state_t   state, state_nx;
  fault_mode_t  mode;
  logic [CNT_W-1:0] tmr_cnt, tmr_limit;
  logic tmr_expire, tmr_clr;
  logic blank_done, run_cont, enter_start, start_ok;

  // ---------------- interval selection ----------------
  always_comb begin
    case (state)
      S_DEBOUNCE: tmr_limit = CNT_W'(DEB_TICKS);
      S_START:    tmr_limit = CNT_W'(STO_TICKS);
      S_RUN:      tmr_limit = CNT_W'(BLANK_TICKS);
      S_RETRY:    tmr_limit = CNT_W'(RETRY_TICKS);
      default:    tmr_limit = CNT_W'(LONGEST);
    endcase
  end

  assign tmr_clr = (state_nx != state) || (state == S_RUN && !oc_det);

  lsw_tick_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick_ms),
    .limit(tmr_limit), .cnt(tmr_cnt), .expire(tmr_expire)
  );

  // named events
  assign blank_done  = (state == S_RUN) && oc_det && tmr_expire && (mode != M_CONT);
  assign run_cont    = (state == S_RUN) && (mode == M_CONT);
  assign enter_start = (state_nx == S_START) && (state != S_START);
  assign start_ok    = (state == S_START) && (state_nx == S_RUN);

  lsw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .force_cont(enter_start),
    .sample(start_ok), .sel(mode_sel), .mode(mode)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    state_nx = state;
    if (!enable || clear_fault) begin
      state_nx = S_IDLE;
    end else begin
      case (state)
        S_IDLE:     state_nx = S_DEBOUNCE;
        S_DEBOUNCE: if (tmr_expire) state_nx = S_START;
        S_START: begin
          if (therm_sd)        state_nx = S_THERM;
          else if (tmr_expire) state_nx = out_charged ? S_RUN : S_LATCH;
        end
        S_RUN: begin
          if (therm_sd)        state_nx = (mode == M_LATCH) ? S_LATCH : S_THERM;
          else if (blank_done) state_nx = (mode == M_LATCH) ? S_LATCH : S_RETRY;
        end
        S_RETRY:    if (tmr_expire) state_nx = S_START;
        S_THERM:    if (therm_ok && !therm_sd)
                      state_nx = (mode == M_RETRY) ? S_RETRY : S_DEBOUNCE;
        S_LATCH:    state_nx = S_LATCH;
        default:    state_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  assign sw_on        = (state == S_START) || (state == S_RUN);
  assign ilim_mult    = (state == S_START && tmr_cnt < CNT_W'(STI_TICKS))
                        ? boost_code(boost_cfg) : 2'b00;
  assign latched_off  = (state == S_LATCH);
  assign retry_active = (state == S_RETRY);

  // ---------------- assertions ----------------
  p_enable_low_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !sw_on);

  p_mult_stays_1x_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_on && $past(sw_on) && $past(ilim_mult) == 2'b00) |-> ilim_mult == 2'b00);

  p_retry_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_active) |-> $past(blank_done || therm_ok));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latched_off) && $past(enable) && !$past(clear_fault)) |-> latched_off);

  p_retry_to_startup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(retry_active) && $past(enable) && !$past(clear_fault)) |-> sw_on);

  p_cont_stays_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_cont && enable && !clear_fault && !therm_sd) |-> sw_on);

endmodule

// File: tb/tb_lsw_seq_top.sv
`timescale 1ns/1ps
module tb_lsw_seq_top;
  logic clk = 1'b0;
  logic rst_n, tick_ms, enable, clear_fault, oc_det, out_charged, therm_sd, therm_ok;
  logic [1:0] mode_sel, boost_cfg, ilim_mult;
  logic sw_on, latched_off, retry_active;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lsw_seq_top dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .enable(enable),
    .clear_fault(clear_fault), .oc_det(oc_det), .out_charged(out_charged),
    .therm_sd(therm_sd), .therm_ok(therm_ok), .mode_sel(mode_sel),
    .boost_cfg(boost_cfg), .sw_on(sw_on), .ilim_mult(ilim_mult),
    .latched_off(latched_off), .retry_active(retry_active)
  );

  // mode, boost cfg, expected mult, on after trip, latched, retrying
  typedef struct packed {
    logic [1:0] msel; logic [1:0] bcfg; logic [1:0] emult;
    logic eon; logic elat; logic eret;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    '{2'b01, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1},
    '{2'b10, 2'b10, 2'b10, 1'b1, 1'b0, 1'b0},
    '{2'b11, 2'b11, 2'b10, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    enable = 1'b0;
    step(1);
    chk("R1 off after enable low", sw_on, 0);
    chk("R1 lock released", latched_off, 0);
  endtask

  // full startup from idle; ends on the edge that closes the window
  task automatic do_start(input logic [1:0] msel, input logic [1:0] bcfg,
                          input logic [1:0] emult, input logic charged);
    mode_sel = msel; boost_cfg = bcfg; out_charged = charged; enable = 1'b1;
    step(2);
    chk("R1 open during debounce", sw_on, 0);
    step(1);
    chk("R1 closed after debounce", sw_on, 1);
    chk("R2 boost at start", ilim_mult, emult);
    step(23);
    chk("R2 boost last tick", ilim_mult, emult);
    step(1);
    chk("R2 1x after boost", ilim_mult, 0);
    step(1175);
    chk("R3 still in window", sw_on, 1);
    step(1);
  endtask

  initial begin
    rst_n = 1'b0; tick_ms = 1'b1; enable = 1'b0; clear_fault = 1'b0;
    oc_det = 1'b0; out_charged = 1'b0; therm_sd = 1'b0; therm_ok = 1'b0;
    mode_sel = 2'b00; boost_cfg = 2'b00;
    step(3);
    chk("R1 reset sw_on", sw_on, 0);
    chk("R6 reset latched", latched_off, 0);
    chk("R7 reset retry", retry_active, 0);
    chk("R2 reset mult", ilim_mult, 0);
    rst_n = 1'b1;
    step(2);

    // table of fault modes
    for (int i = 0; i < 4; i++) begin
      do_start(VECS[i].msel, VECS[i].bcfg, VECS[i].emult, 1'b1);
      chk("R4 running after startup", sw_on, 1);
      oc_det = 1'b1;
      step(23);
      chk("R5 on before blank ends", sw_on, 1);
      step(1);
      chk("R5 R8 switch after blank", sw_on, VECS[i].eon);
      chk("R6 latched per mode", latched_off, VECS[i].elat);
      chk("R7 retry per mode", retry_active, VECS[i].eret);
      oc_det = 1'b0;
      go_idle();
    end

    // R10 tick gating
    tick_ms = 1'b0; enable = 1'b1;
    step(10);
    chk("R10 no progress without tick", sw_on, 0);
    tick_ms = 1'b1;
    step(1);
    chk("R10 one tick not enough", sw_on, 0);
    step(1);
    chk("R10 on after two ticks", sw_on, 1);
    go_idle();

    // R4 overcurrent ignored in startup, select read once
    oc_det = 1'b1;
    do_start(2'b00, 2'b00, 2'b00, 1'b1);
    chk("R4 oc ignored in startup", sw_on, 1);
    mode_sel = 2'b01;
    step(23);
    chk("R4 on before blank", sw_on, 1);
    step(1);
    chk("R4 lock mode kept", latched_off, 1);
    chk("R4 no retry from late select", retry_active, 0);
    oc_det = 1'b0;
    step(100);
    chk("R6 lock held", latched_off, 1);
    chk("R6 switch held open", sw_on, 0);
    clear_fault = 1'b1;
    step(1);
    clear_fault = 1'b0;
    chk("R6 clear_fault to idle", latched_off, 0);
    go_idle();

    // R5 blank restart, R7 retry duration
    do_start(2'b01, 2'b10, 2'b10, 1'b1);
    oc_det = 1'b1; step(20);
    oc_det = 1'b0; step(1);
    oc_det = 1'b1; step(23);
    chk("R5 gap restarted count", sw_on, 1);
    step(1);
    chk("R5 trip after full blank", retry_active, 1);
    step(719);
    chk("R7 still retrying", retry_active, 1);
    chk("R7 open while retrying", sw_on, 0);
    step(1);
    chk("R7 restart closes switch", sw_on, 1);
    chk("R7 restart boost", ilim_mult, 2);
    oc_det = 1'b0;
    step(1200);
    chk("R7 running again", sw_on, 1);

    // R9 thermal in retry mode
    therm_sd = 1'b1; step(1);
    chk("R9 thermal opens", sw_on, 0);
    chk("R9 retry waits for recovery", retry_active, 0);
    step(50);
    therm_sd = 1'b0; therm_ok = 1'b1; step(1);
    therm_ok = 1'b0;
    chk("R9 retry after recovery", retry_active, 1);
    step(719);
    chk("R9 retry length", sw_on, 0);
    step(1);
    chk("R9 on after retry", sw_on, 1);
    go_idle();

    // R8 continuous, R9 thermal with debounce only
    do_start(2'b10, 2'b01, 2'b01, 1'b1);
    oc_det = 1'b1; step(200);
    chk("R8 long overcurrent keeps on", sw_on, 1);
    oc_det = 1'b0;
    therm_sd = 1'b1; step(1);
    chk("R9 continuous thermal opens", sw_on, 0);
    therm_sd = 1'b0; therm_ok = 1'b1; step(1);
    therm_ok = 1'b0;
    chk("R9 debounce after recovery", sw_on, 0);
    chk("R9 no retry in continuous", retry_active, 0);
    step(1);
    chk("R9 still debouncing", sw_on, 0);
    step(1);
    chk("R9 on after debounce", sw_on, 1);
    chk("R9 startup boost again", ilim_mult, 1);
    go_idle();

    // R9 thermal in lock-off mode
    do_start(2'b00, 2'b00, 2'b00, 1'b1);
    therm_sd = 1'b1; step(1);
    chk("R9 lock mode thermal locks", latched_off, 1);
    therm_sd = 1'b0; therm_ok = 1'b1; step(20);
    therm_ok = 1'b0;
    chk("R9 recovery does not unlock", latched_off, 1);
    go_idle();

    // R3 startup timeout
    do_start(2'b01, 2'b00, 2'b00, 1'b0);
    chk("R3 timeout locks", latched_off, 1);
    chk("R3 timeout opens", sw_on, 0);
    step(50);
    chk("R3 lock held", latched_off, 1);
    go_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule